// File: doc/BRIEF.md
# Aliased Sub-Word Register File

A general-purpose register file of eight 32-bit registers whose narrower views overlap the same physical storage. Every register can be accessed as a full word or as its low 16-bit half. The first four registers can also be accessed as either byte of that half. One write port takes an index, an access size and data. A narrow write merges into the stored word and leaves the other bits as they were. Two read ports each take an index and a size and return the selected slice, zero-extended to 32 bits.

Next to the file sits a 32-bit program counter. It can be loaded with a new target or advanced by a variable amount of 1 to 15. A load takes precedence over an advance. All state updates on the rising clock edge. Reads are combinational, so a read in the same cycle as a write to the same register still returns the value stored before that write.

Top module: `alias_regfile`

## Requirements
- R1: With size code 2'b10 (word), a write replaces all 32 bits of register `wrIdx`, and a read returns all 32 bits of register `rdIdx`.
- R2: With size code 2'b01 (half), a write replaces only bits [15:0] of register `wrIdx`, and a read returns bits [15:0] of that register.
- R3: With size code 2'b00 (byte) and index 0 to 3, a write replaces only bits [7:0] of that register, and a read returns bits [7:0] of it.
- R4: With size code 2'b00 (byte) and index 4 to 7, the access targets bits [15:8] of register index-4. A write puts `wrData[7:0]` into those bits and changes nothing else, and a read returns them in bits [7:0].
- R5: Size code 2'b11 is reserved. A write with it changes no register, and a read with it returns zero.
- R6: Every byte read has bits [31:8] at zero, and every half read has bits [31:16] at zero.
- R7: A read of a register in the same cycle as a write to it returns the value held before that write. The new value is readable from the cycle after the clock edge.
- R8: The two read ports select their register and size independently of each other.
- R9: Synchronous active-high reset clears all eight registers and loads `RESET_VEC` into the program counter.
- R10: When `pcLoad` is high, the program counter takes `pcLoadVal` at the next edge, whatever `pcInc` is.
- R11: When `pcInc` is high and `pcLoad` is low, the program counter advances by `pcIncAmt` (1 to 15), wrapping modulo 2^32. When both are low, it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Write enable |
| wrIdx | input | 3 | Write register index |
| wrSize | input | 2 | Write access size code |
| wrData | input | 32 | Write data, right-aligned |
| rdIdxA | input | 3 | Read port A index |
| rdSizeA | input | 2 | Read port A size code |
| rdDataA | output | 32 | Read port A data, zero-extended |
| rdIdxB | input | 3 | Read port B index |
| rdSizeB | input | 2 | Read port B size code |
| rdDataB | output | 32 | Read port B data, zero-extended |
| pcLoad | input | 1 | Load program counter |
| pcLoadVal | input | 32 | Program counter load value |
| pcInc | input | 1 | Advance program counter |
| pcIncAmt | input | 4 | Advance amount |
| pcOut | output | 32 | Program counter value |

## Verification
The bench builds the block with its default widths and a `RESET_VEC` of 32'h0000_7FF0. This reset vector is distinct from zero, so a counter that only clears on reset is caught. With eight registers and four size codes, the bench can sweep every index and size combination for writes. After each write it reads back every combination on both ports and compares against an arithmetic model of the aliasing. The four-bit advance amount is also swept over all values from 1 to 15, including a wrap past 2^32.

// File: rtl/alias_regfile_pkg.sv
package alias_regfile_pkg;
  localparam int DATA_W    = 32;
  localparam int HALF_W    = 16;
  localparam int BYTE_W    = 8;
  localparam int NUM_REGS  = 8;
  localparam int BYTE_REGS = 4;
  localparam int NUM_RD    = 2;
  localparam int IDX_W     = $clog2(NUM_REGS);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_NONE = 2'b11
  } accSize_e;

  typedef enum logic [2:0] {
    VW_ZERO, VW_LOBYTE, VW_HIBYTE, VW_HALF, VW_WORD
  } rdView_e;

  typedef struct packed {
    logic [NUM_REGS-1:0] regHit;
    logic                laneLo;
    logic                laneHi;
    logic                laneUp;
    logic                hiShift;
    logic                pcLoad;
    logic                pcAdv;
  } ctrlStb_t;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    rdView_e          view;
  } rdSel_t;
endpackage

// File: rtl/alias_regfile_ctrl.sv
module alias_regfile_ctrl
  import alias_regfile_pkg::*;
(
  input  logic                           wrEn,
  input  logic [IDX_W-1:0]               wrIdx,
  input  logic [1:0]                     wrSize,
  input  logic [NUM_RD-1:0][IDX_W-1:0]   rdIdx,
  input  logic [NUM_RD-1:0][1:0]         rdSize,
  input  logic                           pcLoad,
  input  logic                           pcInc,
  output ctrlStb_t                       stb,
  output rdSel_t [NUM_RD-1:0]            rdSel
);
  localparam logic [IDX_W-1:0] BYTE_SPLIT = IDX_W'(BYTE_REGS);

  always_comb begin
    stb = '0;
    if (wrEn) begin
      case (accSize_e'(wrSize))
        SZ_BYTE: begin
          if (wrIdx < BYTE_SPLIT) begin
            stb.regHit[wrIdx] = 1'b1;
            stb.laneLo        = 1'b1;
          end else begin
            stb.regHit[wrIdx - BYTE_SPLIT] = 1'b1;
            stb.laneHi  = 1'b1;
            stb.hiShift = 1'b1;
          end
        end
        SZ_HALF: begin
          stb.regHit[wrIdx] = 1'b1;
          stb.laneLo        = 1'b1;
          stb.laneHi        = 1'b1;
        end
        SZ_WORD: begin
          stb.regHit[wrIdx] = 1'b1;
          stb.laneLo        = 1'b1;
          stb.laneHi        = 1'b1;
          stb.laneUp        = 1'b1;
        end
        default: ;
      endcase
    end
    stb.pcLoad = pcLoad;
    stb.pcAdv  = pcInc & ~pcLoad;
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rdDec
    always_comb begin
      rdSel[p].idx  = rdIdx[p];
      rdSel[p].view = VW_ZERO;
      case (accSize_e'(rdSize[p]))
        SZ_BYTE: begin
          if (rdIdx[p] < BYTE_SPLIT) begin
            rdSel[p].view = VW_LOBYTE;
          end else begin
            rdSel[p].idx  = rdIdx[p] - BYTE_SPLIT;
            rdSel[p].view = VW_HIBYTE;
          end
        end
        SZ_HALF: rdSel[p].view = VW_HALF;
        SZ_WORD: rdSel[p].view = VW_WORD;
        default: rdSel[p].view = VW_ZERO;
      endcase
    end
  end
endmodule

// File: rtl/alias_regfile_dp.sv
module alias_regfile_dp
  import alias_regfile_pkg::*;
#(
  parameter int                PC_STEP_W = 4,
  parameter logic [DATA_W-1:0] RESET_VEC = 32'hFFFF_FFF0
) (
  input  logic                          clk,
  input  logic                          rst,
  input  ctrlStb_t                      stb,
  input  logic [DATA_W-1:0]             wrData,
  input  rdSel_t [NUM_RD-1:0]           rdSel,
  input  logic [DATA_W-1:0]             pcLoadVal,
  input  logic [PC_STEP_W-1:0]          pcIncAmt,
  output logic [NUM_RD-1:0][DATA_W-1:0] rdData,
  output logic [DATA_W-1:0]             pcOut
);
  logic [DATA_W-1:0] regView [NUM_REGS];
  logic [BYTE_W-1:0] hiLaneData;

  assign hiLaneData = stb.hiShift ? wrData[BYTE_W-1:0] : wrData[HALF_W-1:BYTE_W];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] word;
    always_ff @(posedge clk) begin
      if (rst) begin
        word <= '0;
      end else if (stb.regHit[g]) begin
        if (stb.laneLo) word[BYTE_W-1:0]      <= wrData[BYTE_W-1:0];
        if (stb.laneHi) word[HALF_W-1:BYTE_W] <= hiLaneData;
        if (stb.laneUp) word[DATA_W-1:HALF_W] <= wrData[DATA_W-1:HALF_W];
      end
    end
    assign regView[g] = word;
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rdMux
    logic [DATA_W-1:0] picked;
    assign picked = regView[rdSel[p].idx];
    always_comb begin
      case (rdSel[p].view)
        VW_LOBYTE: rdData[p] = DATA_W'(picked[BYTE_W-1:0]);
        VW_HIBYTE: rdData[p] = DATA_W'(picked[HALF_W-1:BYTE_W]);
        VW_HALF:   rdData[p] = DATA_W'(picked[HALF_W-1:0]);
        VW_WORD:   rdData[p] = picked;
        default:   rdData[p] = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             pcOut <= RESET_VEC;
    else if (stb.pcLoad) pcOut <= pcLoadVal;
    else if (stb.pcAdv)  pcOut <= pcOut + DATA_W'(pcIncAmt);
  end
endmodule

// File: rtl/alias_regfile.sv
module alias_regfile
  import alias_regfile_pkg::*;
#(
  parameter int                PC_STEP_W = 4,
  parameter logic [DATA_W-1:0] RESET_VEC = 32'hFFFF_FFF0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wrEn,
  input  logic [IDX_W-1:0]     wrIdx,
  input  logic [1:0]           wrSize,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [IDX_W-1:0]     rdIdxA,
  input  logic [1:0]           rdSizeA,
  output logic [DATA_W-1:0]    rdDataA,
  input  logic [IDX_W-1:0]     rdIdxB,
  input  logic [1:0]           rdSizeB,
  output logic [DATA_W-1:0]    rdDataB,
  input  logic                 pcLoad,
  input  logic [DATA_W-1:0]    pcLoadVal,
  input  logic                 pcInc,
  input  logic [PC_STEP_W-1:0] pcIncAmt,
  output logic [DATA_W-1:0]    pcOut
);
  ctrlStb_t                       stb;
  rdSel_t [NUM_RD-1:0]            rdSel;
  logic [NUM_RD-1:0][DATA_W-1:0]  rdData;

  alias_regfile_ctrl u_ctrl (
    .wrEn   (wrEn),
    .wrIdx  (wrIdx),
    .wrSize (wrSize),
    .rdIdx  ({rdIdxB, rdIdxA}),
    .rdSize ({rdSizeB, rdSizeA}),
    .pcLoad (pcLoad),
    .pcInc  (pcInc),
    .stb    (stb),
    .rdSel  (rdSel)
  );

  alias_regfile_dp #(
    .PC_STEP_W (PC_STEP_W),
    .RESET_VEC (RESET_VEC)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .stb       (stb),
    .wrData    (wrData),
    .rdSel     (rdSel),
    .pcLoadVal (pcLoadVal),
    .pcIncAmt  (pcIncAmt),
    .rdData    (rdData),
    .pcOut     (pcOut)
  );

  assign rdDataA = rdData[0];
  assign rdDataB = rdData[1];
endmodule

// File: rtl/alias_regfile_chk.sv
module alias_regfile_chk
  import alias_regfile_pkg::*;
#(
  parameter int                PC_STEP_W = 4,
  parameter logic [DATA_W-1:0] RESET_VEC = 32'hFFFF_FFF0
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wrEn,
  input logic [IDX_W-1:0]     wrIdx,
  input logic [1:0]           wrSize,
  input logic [DATA_W-1:0]    wrData,
  input logic [IDX_W-1:0]     rdIdxA,
  input logic [1:0]           rdSizeA,
  input logic [DATA_W-1:0]    rdDataA,
  input logic [1:0]           rdSizeB,
  input logic [DATA_W-1:0]    rdDataB,
  input logic                 pcLoad,
  input logic [DATA_W-1:0]    pcLoadVal,
  input logic                 pcInc,
  input logic [PC_STEP_W-1:0] pcIncAmt,
  input logic [DATA_W-1:0]    pcOut
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  assert_reset_pc_R9: assert property (@(posedge clk) disable iff (!armed)
    $past(rst) |-> pcOut == RESET_VEC);

  assert_pc_load_R10: assert property (@(posedge clk) disable iff (rst || !armed)
    (!$past(rst) && $past(pcLoad)) |-> pcOut == $past(pcLoadVal));

  assert_pc_step_R11: assert property (@(posedge clk) disable iff (rst || !armed)
    (!$past(rst) && !$past(pcLoad) && $past(pcInc))
      |-> pcOut == $past(pcOut) + DATA_W'($past(pcIncAmt)));

  assert_pc_hold_R11: assert property (@(posedge clk) disable iff (rst || !armed)
    (!$past(rst) && !$past(pcLoad) && !$past(pcInc)) |-> $stable(pcOut));

  assert_rsvd_read_R5: assert property (@(posedge clk) disable iff (rst)
    (rdSizeA == 2'b11) |-> rdDataA == '0);

  assert_rsvd_read_b_R5: assert property (@(posedge clk) disable iff (rst)
    (rdSizeB == 2'b11) |-> rdDataB == '0);

  assert_zext_byte_R6: assert property (@(posedge clk) disable iff (rst)
    (rdSizeA == 2'b00) |-> rdDataA[DATA_W-1:BYTE_W] == '0);

  assert_zext_half_R6: assert property (@(posedge clk) disable iff (rst)
    (rdSizeB == 2'b01) |-> rdDataB[DATA_W-1:HALF_W] == '0);

  assert_word_visible_R7: assert property (@(posedge clk) disable iff (rst || !armed)
    (!$past(rst) && $past(wrEn) && $past(wrSize) == 2'b10
      && rdSizeA == 2'b10 && rdIdxA == $past(wrIdx)) |-> rdDataA == $past(wrData));
endmodule

bind alias_regfile alias_regfile_chk #(
  .PC_STEP_W (PC_STEP_W),
  .RESET_VEC (RESET_VEC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wrEn      (wrEn),
  .wrIdx     (wrIdx),
  .wrSize    (wrSize),
  .wrData    (wrData),
  .rdIdxA    (rdIdxA),
  .rdSizeA   (rdSizeA),
  .rdDataA   (rdDataA),
  .rdSizeB   (rdSizeB),
  .rdDataB   (rdDataB),
  .pcLoad    (pcLoad),
  .pcLoadVal (pcLoadVal),
  .pcInc     (pcInc),
  .pcIncAmt  (pcIncAmt),
  .pcOut     (pcOut)
);

// File: tb/alias_regfile_tb.sv
module alias_regfile_tb;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] VEC        = 32'h0000_7FF0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [2:0]  wrIdx = '0;
  logic [1:0]  wrSize = '0;
  logic [31:0] wrData = '0;
  logic [2:0]  rdIdxA = '0, rdIdxB = '0;
  logic [1:0]  rdSizeA = '0, rdSizeB = '0;
  logic [31:0] rdDataA, rdDataB;
  logic        pcLoad = 1'b0, pcInc = 1'b0;
  logic [31:0] pcLoadVal = '0;
  logic [3:0]  pcIncAmt = '0;
  logic [31:0] pcOut;

  int checks = 0;
  int fails  = 0;
  logic [31:0] mdl [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  alias_regfile #(.PC_STEP_W(4), .RESET_VEC(VEC)) u_dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrIdx(wrIdx), .wrSize(wrSize), .wrData(wrData),
    .rdIdxA(rdIdxA), .rdSizeA(rdSizeA), .rdDataA(rdDataA),
    .rdIdxB(rdIdxB), .rdSizeB(rdSizeB), .rdDataB(rdDataB),
    .pcLoad(pcLoad), .pcLoadVal(pcLoadVal), .pcInc(pcInc), .pcIncAmt(pcIncAmt), .pcOut(pcOut));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input int r, input int s);
    case (s)
      0: return (r < 4) ? {24'h0, mdl[r][7:0]} : {24'h0, mdl[r-4][15:8]};
      1: return {16'h0, mdl[r][15:0]};
      2: return mdl[r];
      default: return 32'h0;
    endcase
  endfunction

  function automatic string readTag(input int r, input int s);
    case (s)
      0: return (r < 4) ? "R3" : "R4";
      1: return "R2";
      2: return "R1";
      default: return "R5";
    endcase
  endfunction

  task automatic mdlWrite(input int r, input int s, input logic [31:0] d);
    case (s)
      0: if (r < 4) mdl[r][7:0] = d[7:0]; else mdl[r-4][15:8] = d[7:0];
      1: mdl[r][15:0] = d[15:0];
      2: mdl[r] = d;
      default: ;
    endcase
  endtask

  task automatic sweepReads();
    for (int r = 0; r < 8; r++) begin
      for (int s = 0; s < 4; s++) begin
        rdIdxA = 3'(r); rdSizeA = 2'(s);
        rdIdxB = 3'((r + 3) % 8); rdSizeB = 2'(3 - s);
        #1;
        chk(readTag(r, s), rdDataA, expRead(r, s));
        chk("R8 port B", rdDataB, expRead((r + 3) % 8, 3 - s));
        if (s == 0) chk("R6 byte zext", {8'h0, rdDataA[31:8]}, 32'h0);
        if (s == 1) chk("R6 half zext", {16'h0, rdDataA[31:16]}, 32'h0);
      end
    end
  endtask

  task automatic doWrite(input int r, input int s, input logic [31:0] d);
    int tgt;
    tgt = (s == 0 && r >= 4) ? r - 4 : r;
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 3'(r); wrSize = 2'(s); wrData = d;
    rdIdxA = 3'(tgt); rdSizeA = 2'b10;
    #1;
    chk("R7 old value on same-cycle read", rdDataA, mdl[tgt]);
    @(posedge clk);
    mdlWrite(r, s, d);
    @(negedge clk);
    wrEn = 1'b0;
    rdIdxA = 3'(tgt); rdSizeA = 2'b10;
    #1;
    chk((s == 3) ? "R5 reserved write no effect" : "R7 new value next cycle", rdDataA, mdl[tgt]);
  endtask

  task automatic stepPc(input logic ld, input logic [31:0] lv, input logic inc,
                        input logic [3:0] amt, input logic [31:0] exp, input string tag);
    @(negedge clk);
    pcLoad = ld; pcLoadVal = lv; pcInc = inc; pcIncAmt = amt;
    @(negedge clk);
    pcLoad = 1'b0; pcInc = 1'b0;
    chk(tag, pcOut, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] pcExp;
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 reset pc", pcOut, VEC);
    sweepReads();

    for (int p = 0; p < 3; p++)
      for (int r = 0; r < 8; r++)
        for (int s = 0; s < 4; s++) begin
          doWrite(r, s, 32'h9E37_79B9 * 32'(p * 37 + r * 4 + s + 1));
          sweepReads();
        end

    doWrite(2, 2, 32'hDEAD_BEEF);
    doWrite(6, 0, 32'hFFFF_FF5A);
    chk("R4 high byte merge", mdl[2], 32'hDEAD_5AEF);
    doWrite(2, 0, 32'h0000_0011);
    chk("R3 low byte merge", mdl[2], 32'hDEAD_5A11);
    @(negedge clk); rdIdxA = 3'd2; rdSizeA = 2'b10; #1;
    chk("R3 R4 combined word", rdDataA, 32'hDEAD_5A11);

    pcExp = VEC;
    for (int a = 1; a < 16; a++) begin
      pcExp = pcExp + 32'(a);
      stepPc(1'b0, 32'h0, 1'b1, 4'(a), pcExp, "R11 advance");
    end
    stepPc(1'b0, 32'h0, 1'b0, 4'd5, pcExp, "R11 hold");
    stepPc(1'b1, 32'hFFFF_FFFC, 1'b1, 4'd7, 32'hFFFF_FFFC, "R10 load beats advance");
    stepPc(1'b0, 32'h0, 1'b1, 4'd15, 32'h0000_000B, "R11 wrap");
    stepPc(1'b1, 32'h1234_5678, 1'b0, 4'd0, 32'h1234_5678, "R10 load");

    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    chk("R9 reset pc again", pcOut, VEC);
    for (int r = 0; r < 8; r++) begin
      rdIdxA = 3'(r); rdSizeA = 2'b10; #1;
      chk("R9 reset clears register", rdDataA, 32'h0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule